// File: doc/BRIEF.md
# Interconnect Performance Monitor Counter Unit

This unit counts activity inside one clock domain of an on-chip network. It has a bank of event counters, eight by default, each 32 bits wide, and one 64-bit cycle counter. Each event counter has a selector register that names one monitored node by a node type and a node id. The counter adds one in each cycle in which a node carrying that exact tag raises its event line. Every node reports its tag and its event pulse on the `node_tag` and `node_evt` buses.

Software uses a 32-bit register bus with APB-style timing. A write takes effect at the clock edge that ends the access phase, and read data is valid during the access phase. Counter enable, interrupt enable and overflow status are 32-bit masks, each set and cleared through its own register. A control register holds the global count enable and two self-clearing counter resets. The interrupt output is high whenever an overflow bit is set and its interrupt enable is also set.

Top module: `noc_perfmon`

## Requirements
- R1: After reset, all counters, selectors, mask registers and the control register read zero, and `irq` is low.
- R2: Offset 0xE00 reads the constant 0x108: bits [7:0] give the event counter count and bit 8 shows that the cycle counter is present. Any offset that is not a defined register reads zero, and writes to it have no effect.
- R3: Enable mask: writing 1s to 0xC00 sets bits and writing 1s to 0xC20 clears them. Both offsets read the mask back. Zero bits in the written data change nothing. Bit n belongs to event counter n, bit 31 belongs to the cycle counter, and all other bits read zero.
- R4: Event counter n advances by one in each cycle in which global enable (0xE04 bit 0) is set, enable bit n is set, and some node whose event line is high has a tag equal to selector n. Both the type and the id must match. Otherwise the counter holds.
- R5: Event counter n is read and written at 0x200 + 8n. A write loads the counter, and the load takes priority over a count in the same cycle.
- R6: When a counter steps from all-ones to zero, its overflow bit is set. Overflow status reads at 0xC80 and 0xCC0. Writing 1s to 0xC80 clears bits, and writing 1s to 0xCC0 sets them.
- R7: Interrupt enable is set through 0xC40 and cleared through 0xC60, and both offsets read the mask back. `irq` equals the OR over all bits of (overflow AND interrupt enable).
- R8: The cycle counter reads and loads its low word at 0x2F8 and its high word at 0x2FC. It adds one every clock while global enable and enable bit 31 are both set. A carry passes from the low word into the high word. A wrap of all 64 bits sets overflow bit 31.
- R9: Control register at 0xE04: bit 0 is the global enable. Writing bit 1 zeroes all event counters, and writing bit 2 zeroes the cycle counter. Bits 1 and 2 take effect once and read back as zero. Writing 0 stops all counting.
- R10: Selector n at 0x400 + 4n holds the node type in bits [12:9] and the node id in bits [8:0]. Higher bits are ignored and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase of a bus transfer |
| pwrite | input | 1 | High for a write transfer |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for `paddr` |
| node_tag | input | NUM_NODES*13 | Tag of each monitored node, {type[3:0], id[8:0]} per node |
| node_evt | input | NUM_NODES | Event pulse of each monitored node |
| irq | output | 1 | Overflow interrupt |

## Verification
The embedded assertions check behaviour that must hold on every cycle:
- an idle counter holds its value;
- a load lands exactly;
- the cycle counter steps by one;
- every wrap sets its overflow bit on the next edge;
- a clear-register write leaves the named enable bits at zero;
- a control reset zeroes all event counters;
- `irq` stays low while no interrupt is enabled.

Only the bench scenarios can show the rest:
- that selector matching needs both type and id;
- that the global enable gates counting;
- the carry from the low word into the high word;
- that reads of undefined offsets return zero.

In those scenarios the behavioural model is compared with the design on every clock.

// File: rtl/noc_perfmon_pkg.sv
package noc_perfmon_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int TYPE_W  = 4;
    localparam int ID_W    = 9;
    localparam int TAG_W   = TYPE_W + ID_W;
    localparam int CYC_BIT = 31;

    localparam logic [ADDR_W-1:0] OFS_EVCNT  = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_CYC_LO = 12'h2F8;
    localparam logic [ADDR_W-1:0] OFS_CYC_HI = 12'h2FC;
    localparam logic [ADDR_W-1:0] OFS_EVSEL  = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'hC00;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'hC20;
    localparam logic [ADDR_W-1:0] OFS_IE_SET = 12'hC40;
    localparam logic [ADDR_W-1:0] OFS_IE_CLR = 12'hC60;
    localparam logic [ADDR_W-1:0] OFS_OV_CLR = 12'hC80;
    localparam logic [ADDR_W-1:0] OFS_OV_SET = 12'hCC0;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 12'hE00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'hE04;

    typedef struct packed {
        logic [TYPE_W-1:0] ntype;
        logic [ID_W-1:0]   nid;
    } node_tag_t;

    typedef enum logic [3:0] {
        RG_NONE, RG_EVCNT, RG_CYC_LO, RG_CYC_HI, RG_EVSEL,
        RG_EN_SET, RG_EN_CLR, RG_IE_SET, RG_IE_CLR,
        RG_OV_CLR, RG_OV_SET, RG_CFG, RG_CTRL
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t  kind;
        logic [4:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int ncnt);
        reg_sel_t r;
        int ia;
        ia = int'(a);
        r.kind = RG_NONE;
        r.idx  = '0;
        if (ia >= int'(OFS_EVCNT) && ia < int'(OFS_EVCNT) + 8 * ncnt && ia[2:0] == 3'd0) begin
            r.kind = RG_EVCNT;
            r.idx  = 5'((ia - int'(OFS_EVCNT)) >> 3);
        end else if (ia >= int'(OFS_EVSEL) && ia < int'(OFS_EVSEL) + 4 * ncnt && ia[1:0] == 2'd0) begin
            r.kind = RG_EVSEL;
            r.idx  = 5'((ia - int'(OFS_EVSEL)) >> 2);
        end else begin
            case (a)
                OFS_CYC_LO: r.kind = RG_CYC_LO;
                OFS_CYC_HI: r.kind = RG_CYC_HI;
                OFS_EN_SET: r.kind = RG_EN_SET;
                OFS_EN_CLR: r.kind = RG_EN_CLR;
                OFS_IE_SET: r.kind = RG_IE_SET;
                OFS_IE_CLR: r.kind = RG_IE_CLR;
                OFS_OV_CLR: r.kind = RG_OV_CLR;
                OFS_OV_SET: r.kind = RG_OV_SET;
                OFS_CFG:    r.kind = RG_CFG;
                OFS_CTRL:   r.kind = RG_CTRL;
                default:    r.kind = RG_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/pm_event_route.sv
module pm_event_route
    import noc_perfmon_pkg::*;
#(
    parameter int NUM_NODES = 4
) (
    input  logic [TAG_W-1:0]           sel,
    input  logic [NUM_NODES*TAG_W-1:0] node_tag,
    input  logic [NUM_NODES-1:0]       node_evt,
    output logic                       hit
);
    node_tag_t                 want;
    logic [NUM_NODES-1:0]      match;

    assign want = node_tag_t'(sel);

    for (genvar k = 0; k < NUM_NODES; k++) begin : g_node
        node_tag_t have;
        assign have     = node_tag_t'(node_tag[k*TAG_W +: TAG_W]);
        assign match[k] = node_evt[k] && (have.ntype == want.ntype) && (have.nid == want.nid);
    end

    assign hit = |match;
endmodule

// File: rtl/pm_event_counter.sv
module pm_event_counter
    import noc_perfmon_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inc,
    output logic [WIDTH-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (wr_en)  cnt <= wr_data;
        else if (inc)    cnt <= cnt + WIDTH'(1);
    end

    assign wrap = inc && !clr && !wr_en && (cnt == '1);

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr_en && !clr) |=> $stable(cnt));
    // R5
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> (cnt == $past(wr_data)));
    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));
endmodule

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter
    import noc_perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inc,
    output logic [2*DATA_W-1:0] cnt,
    output logic              wrap
);
    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (wr_lo)  cnt[DATA_W-1:0] <= wdata;
        else if (wr_hi)  cnt[2*DATA_W-1:DATA_W] <= wdata;
        else if (inc)    cnt <= cnt + (2*DATA_W)'(1);
    end

    assign wrap = inc && !clr && !wr_lo && !wr_hi && (cnt == '1);

    // R8
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + (2*DATA_W)'(1)));
endmodule

// File: rtl/noc_perfmon.sv
module noc_perfmon
    import noc_perfmon_pkg::*;
#(
    parameter int NUM_CNT   = 8,
    parameter int NUM_NODES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [DATA_W-1:0]          pwdata,
    output logic [DATA_W-1:0]          prdata,
    input  logic [NUM_NODES*TAG_W-1:0] node_tag,
    input  logic [NUM_NODES-1:0]       node_evt,
    output logic                       irq
);
    localparam int IDX_W = $clog2(NUM_CNT);
    localparam logic [DATA_W-1:0] IMPL_MASK =
        (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);
    localparam logic [DATA_W-1:0] CFG_VALUE = 32'(NUM_CNT) | 32'h100;

    reg_sel_t rs;
    logic     wr, clr_ev, clr_cyc, glob_q, cyc_wrap;
    logic [DATA_W-1:0] cen_q, ien_q, ovf_q, wmask, wrap_vec;
    logic [NUM_CNT-1:0][TAG_W-1:0]  sel_q;
    logic [NUM_CNT-1:0][DATA_W-1:0] evc;
    logic [NUM_CNT-1:0] ev_hit, ev_wrap;
    logic [2*DATA_W-1:0] cyc;

    assign rs      = decode_addr(paddr, NUM_CNT);
    assign wr      = psel && penable && pwrite;
    assign wmask   = pwdata & IMPL_MASK;
    assign clr_ev  = wr && (rs.kind == RG_CTRL) && pwdata[1];
    assign clr_cyc = wr && (rs.kind == RG_CTRL) && pwdata[2];

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        pm_event_route #(.NUM_NODES(NUM_NODES)) u_route (
            .sel(sel_q[n]), .node_tag(node_tag), .node_evt(node_evt), .hit(ev_hit[n])
        );
        pm_event_counter #(.WIDTH(DATA_W)) u_count (
            .clk(clk), .rst(rst), .clr(clr_ev),
            .wr_en(wr && (rs.kind == RG_EVCNT) && (rs.idx == 5'(n))),
            .wr_data(pwdata),
            .inc(glob_q && cen_q[n] && ev_hit[n]),
            .cnt(evc[n]), .wrap(ev_wrap[n])
        );
    end

    pm_cycle_counter u_cycle (
        .clk(clk), .rst(rst), .clr(clr_cyc),
        .wr_lo(wr && (rs.kind == RG_CYC_LO)),
        .wr_hi(wr && (rs.kind == RG_CYC_HI)),
        .wdata(pwdata),
        .inc(glob_q && cen_q[CYC_BIT]),
        .cnt(cyc), .wrap(cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        wrap_vec[NUM_CNT-1:0] = ev_wrap;
        wrap_vec[CYC_BIT]     = cyc_wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q <= 1'b0;
            cen_q  <= '0;
            ien_q  <= '0;
            ovf_q  <= '0;
            sel_q  <= '0;
        end else begin
            if (wr && rs.kind == RG_CTRL)   glob_q <= pwdata[0];
            if (wr && rs.kind == RG_EN_SET) cen_q  <= cen_q | wmask;
            if (wr && rs.kind == RG_EN_CLR) cen_q  <= cen_q & ~wmask;
            if (wr && rs.kind == RG_IE_SET) ien_q  <= ien_q | wmask;
            if (wr && rs.kind == RG_IE_CLR) ien_q  <= ien_q & ~wmask;
            ovf_q <= (ovf_q & ~((wr && rs.kind == RG_OV_CLR) ? wmask : '0))
                   | ((wr && rs.kind == RG_OV_SET) ? wmask : '0)
                   | wrap_vec;
            for (int n = 0; n < NUM_CNT; n++) begin
                if (wr && rs.kind == RG_EVSEL && rs.idx == 5'(n))
                    sel_q[n] <= pwdata[TAG_W-1:0];
            end
        end
    end

    always_comb begin
        case (rs.kind)
            RG_EVCNT:             prdata = evc[rs.idx[IDX_W-1:0]];
            RG_EVSEL:             prdata = 32'(sel_q[rs.idx[IDX_W-1:0]]);
            RG_CYC_LO:            prdata = cyc[DATA_W-1:0];
            RG_CYC_HI:            prdata = cyc[2*DATA_W-1:DATA_W];
            RG_EN_SET, RG_EN_CLR: prdata = cen_q;
            RG_IE_SET, RG_IE_CLR: prdata = ien_q;
            RG_OV_CLR, RG_OV_SET: prdata = ovf_q;
            RG_CFG:               prdata = CFG_VALUE;
            RG_CTRL:              prdata = {31'b0, glob_q};
            default:              prdata = '0;
        endcase
    end

    assign irq = |(ovf_q & ien_q);

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && rs.kind == RG_EN_CLR) |=> ((cen_q & $past(pwdata)) == '0));
    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));
    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);
    // R9
    ev_reset_chk: assert property (@(posedge clk) disable iff (rst)
        clr_ev |=> (evc == '0));
endmodule

// File: tb/noc_perfmon_tb.sv
module noc_perfmon_tb;
    localparam int NC = 8;
    localparam int NN = 4;

    logic        clk = 1'b0, rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NN*13-1:0] node_tag;
    logic [NN-1:0]    node_evt = '0;
    logic        irq;

    always #5 clk = ~clk;

    assign node_tag = {4'd7, 9'd2, 4'd4, 9'h1FF, 4'd5, 9'd5, 4'd4, 9'd5};

    noc_perfmon #(.NUM_CNT(NC), .NUM_NODES(NN)) u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .node_tag(node_tag), .node_evt(node_evt), .irq(irq)
    );

    int checks = 0, errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference model
    logic [31:0] m_cen, m_ien, m_ovf, m_wv;
    logic        m_glob, m_bw, m_hit, m_written;
    logic [63:0] m_cyc;
    logic [31:0] m_ev [NC];
    logic [12:0] m_sel[NC];
    int          m_a;
    localparam logic [31:0] MSK = 32'h8000_00FF;

    always @(posedge clk) begin
        if (rst) begin
            m_cen = 0; m_ien = 0; m_ovf = 0; m_glob = 0; m_cyc = 0;
            for (int n = 0; n < NC; n++) begin m_ev[n] = 0; m_sel[n] = 0; end
        end else begin
            m_bw = psel && penable && pwrite;
            m_a  = int'(paddr);
            m_wv = 0;
            for (int n = 0; n < NC; n++) begin
                m_hit = 0;
                for (int k = 0; k < NN; k++)
                    if (node_evt[k] && node_tag[k*13 +: 13] == m_sel[n]) m_hit = 1;
                m_written = m_bw && (m_a == 'h200 + 8*n || (m_a == 'hE04 && pwdata[1]));
                if (m_glob && m_cen[n] && m_hit && !m_written) begin
                    if (m_ev[n] == 32'hFFFF_FFFF) m_wv[n] = 1;
                    m_ev[n] = m_ev[n] + 1;
                end
            end
            m_written = m_bw && (m_a == 'h2F8 || m_a == 'h2FC || (m_a == 'hE04 && pwdata[2]));
            if (m_glob && m_cen[31] && !m_written) begin
                if (m_cyc == '1) m_wv[31] = 1;
                m_cyc = m_cyc + 1;
            end
            if (m_bw) begin
                case (m_a)
                    'hC00: m_cen = m_cen | (pwdata & MSK);
                    'hC20: m_cen = m_cen & ~(pwdata & MSK);
                    'hC40: m_ien = m_ien | (pwdata & MSK);
                    'hC60: m_ien = m_ien & ~(pwdata & MSK);
                    'hC80: m_ovf = m_ovf & ~(pwdata & MSK);
                    'hCC0: m_ovf = m_ovf | (pwdata & MSK);
                    'h2F8: m_cyc[31:0]  = pwdata;
                    'h2FC: m_cyc[63:32] = pwdata;
                    'hE04: begin
                        m_glob = pwdata[0];
                        if (pwdata[1]) for (int n = 0; n < NC; n++) m_ev[n] = 0;
                        if (pwdata[2]) m_cyc = 0;
                    end
                    default: begin
                        if (m_a >= 'h200 && m_a < 'h200 + 8*NC && m_a % 8 == 0)
                            m_ev[(m_a - 'h200) / 8] = pwdata;
                        else if (m_a >= 'h400 && m_a < 'h400 + 4*NC && m_a % 4 == 0)
                            m_sel[(m_a - 'h400) / 4] = pwdata[12:0];
                    end
                endcase
            end
            m_ovf = m_ovf | m_wv;
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int x;
        x = int'(a);
        if (x >= 'h200 && x < 'h200 + 8*NC && x % 8 == 0) return m_ev[(x - 'h200) / 8];
        if (x >= 'h400 && x < 'h400 + 4*NC && x % 4 == 0) return 32'(m_sel[(x - 'h400) / 4]);
        case (x)
            'h2F8: return m_cyc[31:0];
            'h2FC: return m_cyc[63:32];
            'hC00, 'hC20: return m_cen;
            'hC40, 'hC60: return m_ien;
            'hC80, 'hCC0: return m_ovf;
            'hE00: return 32'h0000_0108;
            'hE04: return {31'b0, m_glob};
            default: return 32'h0;
        endcase
    endfunction

    // R7: interrupt output compared with the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (irq !== |(m_ovf & m_ien)) begin
                errors++;
                $display("FAIL R7 irq actual %0b expected %0b", irq, |(m_ovf & m_ien));
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic chk_rd(input logic [11:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1;
        exp = m_read(a);
        checks++;
        if (prdata !== exp) begin
            errors++;
            $display("FAIL %s addr %h actual %h expected %h", req, a, prdata, exp);
        end
        psel = 0; penable = 0;
    endtask

    task automatic pulse(input int cycles, input logic [NN-1:0] mask, input bit rnd);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            node_evt = rnd ? (lfsr[NN-1:0] & mask) : mask;
        end
        @(negedge clk); node_evt = '0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk_rd(12'hE04, "R1"); chk_rd(12'hC00, "R1"); chk_rd(12'hC40, "R1");
        chk_rd(12'hC80, "R1"); chk_rd(12'h200, "R1"); chk_rd(12'h238, "R1");
        chk_rd(12'h2F8, "R1"); chk_rd(12'h2FC, "R1"); chk_rd(12'h400, "R1");
        // R2 configuration value and undefined offsets
        chk_rd(12'hE00, "R2"); chk_rd(12'h100, "R2"); chk_rd(12'h204, "R2");
        bus_wr(12'h100, 32'hFFFF_FFFF);
        chk_rd(12'h100, "R2"); chk_rd(12'hC00, "R2");
        // R10 selectors
        bus_wr(12'h400, 32'h0000_0805);
        bus_wr(12'h404, 32'h0000_0A05);
        bus_wr(12'h408, 32'h0000_09FF);
        bus_wr(12'h40C, 32'h0000_0806);
        bus_wr(12'h410, 32'hFFFF_E805);
        bus_wr(12'h414, 32'h0000_0E02);
        chk_rd(12'h400, "R10"); chk_rd(12'h410, "R10"); chk_rd(12'h414, "R10");
        // R3 enable set/clear
        bus_wr(12'hC00, 32'h0000_003F);
        chk_rd(12'hC00, "R3");
        bus_wr(12'hC20, 32'h0000_0002);
        chk_rd(12'hC20, "R3");
        bus_wr(12'hC00, 32'h0000_0000);
        chk_rd(12'hC00, "R3");
        // R4 gated by global enable
        pulse(20, 4'hF, 0);
        chk_rd(12'h200, "R4");
        bus_wr(12'hE04, 32'h1);
        pulse(40, 4'hF, 1);
        for (int n = 0; n < 6; n++) chk_rd(12'(12'h200 + 8*n), "R4");
        pulse(25, 4'h5, 1);
        chk_rd(12'h200, "R4"); chk_rd(12'h210, "R4"); chk_rd(12'h220, "R4");
        // R5 preset and R6 wrap of counter 0 with R7 interrupt
        bus_wr(12'h210, 32'h1234_5678);
        chk_rd(12'h210, "R5");
        bus_wr(12'h200, 32'hFFFF_FFFE);
        chk_rd(12'h200, "R5");
        bus_wr(12'hC40, 32'h0000_0001);
        chk_rd(12'hC40, "R7");
        pulse(4, 4'h1, 0);
        chk_rd(12'hC80, "R6"); chk_rd(12'h200, "R6");
        bus_wr(12'hC80, 32'h0000_0001);
        chk_rd(12'hC80, "R6");
        bus_wr(12'hCC0, 32'h8000_0F04);
        chk_rd(12'hCC0, "R6");
        bus_wr(12'hC40, 32'h0000_0004);
        chk_rd(12'hC40, "R7");
        bus_wr(12'hC60, 32'h0000_0004);
        chk_rd(12'hC60, "R7");
        bus_wr(12'hC80, 32'hFFFF_FFFF);
        chk_rd(12'hC80, "R6");
        // R8 cycle counter
        bus_wr(12'hC00, 32'h8000_0000);
        chk_rd(12'h2F8, "R8"); chk_rd(12'h2F8, "R8");
        bus_wr(12'h2FC, 32'h0000_0000);
        bus_wr(12'h2F8, 32'hFFFF_FFF8);
        repeat (12) @(negedge clk);
        chk_rd(12'h2FC, "R8"); chk_rd(12'h2F8, "R8");
        bus_wr(12'hC40, 32'h8000_0000);
        bus_wr(12'h2FC, 32'hFFFF_FFFF);
        bus_wr(12'h2F8, 32'hFFFF_FFF0);
        repeat (20) @(negedge clk);
        chk_rd(12'hC80, "R8"); chk_rd(12'h2FC, "R8"); chk_rd(12'h2F8, "R8");
        // R9 control resets and stop
        bus_wr(12'hE04, 32'h0000_0007);
        chk_rd(12'hE04, "R9"); chk_rd(12'h200, "R9"); chk_rd(12'h2F8, "R9");
        bus_wr(12'hE04, 32'h0000_0000);
        chk_rd(12'h2F8, "R9");
        repeat (10) @(negedge clk);
        chk_rd(12'h2F8, "R9");
        pulse(10, 4'hF, 0);
        chk_rd(12'h208, "R9");
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule